// File: doc/BRIEF.md
# Boot Shadow ROM Decoder

This block decodes chip selects for the low address window that holds the processor's exception vectors. A boot ROM and a RAM both sit in that window. After power-on reset the block is in boot mode. In boot mode, reads in the window enable the ROM, so the stack pointer and the first program address come from nonvolatile storage. Writes in the same window enable the RAM, so start-up code can copy the whole vector table across by reading each word and writing it back to the same address.

When the copy is done, software drives an I/O port bit that pulls the active-low switch input down. On the next clock edge a mode flag moves to RAM mode. From then on, every access in the window, read or write, enables the RAM only. The flag stays in RAM mode until the next power-on reset. Both chip selects are active-low. Both stay high whenever the address strobe is idle or the address lies outside the window.

Top module: `boot_shadow_decode`

## Requirements
- R1: In boot mode, a read (rdWr=1) with asN=0 and an address below 0x400 drives romCsN=0 and ramCsN=1. This covers the stack-pointer and program-start words at 0x000 to 0x007 and the last byte 0x3FF.
- R2: In boot mode, a write (rdWr=0) with asN=0 and an address below 0x400 drives ramCsN=0 and romCsN=1.
- R3: ramSwN sampled low at a rising clk edge while porN=1 puts the block in RAM mode. A read in the window then drives ramCsN=0 and romCsN=1.
- R4: RAM mode persists after ramSwN returns high. Only porN=0 returns the block to boot mode.
- R5: In RAM mode, romCsN stays 1 for every input pattern, and writes in the window drive ramCsN=0.
- R6: With asN=1, both romCsN and ramCsN are 1, whatever the address, direction or mode.
- R7: An address of 0x400 or above leaves both selects at 1, in either mode.
- R8: When porN=0 and ramSwN=0 together, reset wins. After porN is released (with ramSwN released too), a read in the window still selects ROM.
- R9: While porN=0, the block is in boot mode, and both selects are 1 when asN=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the switch input |
| porN | input | 1 | Active-low power-on reset, asynchronous, forces boot mode |
| ramSwN | input | 1 | Active-low request from an I/O port bit to move reads to RAM |
| addr | input | ADDR_W (24) | Byte address from the processor |
| rdWr | input | 1 | 1 = read cycle, 0 = write cycle |
| asN | input | 1 | Active-low address strobe |
| romCsN | output | 1 | Active-low boot ROM select |
| ramCsN | output | 1 | Active-low vector RAM select |

## Verification
The assertions assume that ramSwN only changes while porN is high, apart from the deliberate collision case. They also assume that addr, rdWr and asN are steady around each rising clk edge, because the selects are combinational and the mode flag is clocked. The stimulus changes every input on the falling edge and reads the selects one time unit later. The switch pulse is held low across exactly one rising edge. The vector table is walked once in each mode, so the same address patterns are exercised both before and after the flag moves.

// File: rtl/boot_shadow_pkg.sv
package boot_shadow_pkg;
  // Mode held by the control flag
  typedef enum logic {
    MODE_BOOT = 1'b0,
    MODE_RAM  = 1'b1
  } shadowMode_e;

  // Strobes passed from control to the decode datapath
  typedef struct packed {
    logic readRom;   // reads in the window go to ROM
    logic readRam;   // reads in the window go to RAM
  } ctrlStrobe_t;
endpackage

// File: rtl/boot_shadow_ctrl.sv
module boot_shadow_ctrl
  import boot_shadow_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        ramSwN,
  output ctrlStrobe_t strobe
);
  shadowMode_e modeQ;

  // Set/reset flag: reset has priority, switch only sets, nothing clears
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      modeQ <= MODE_BOOT;
    end else if (!ramSwN) begin
      modeQ <= MODE_RAM;
    end
  end

  always_comb begin
    strobe.readRom = (modeQ == MODE_BOOT);
    strobe.readRam = (modeQ == MODE_RAM);
  end
endmodule

// File: rtl/boot_shadow_dp.sv
module boot_shadow_dp
  import boot_shadow_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int REGION_BYTES = 1024
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdWr,
  input  logic              asN,
  input  ctrlStrobe_t       strobe,
  output logic              romCsN,
  output logic              ramCsN
);
  localparam int REGION_AW = $clog2(REGION_BYTES);

  logic inWindow;

  generate
    if (REGION_AW >= ADDR_W) begin : g_full_space
      assign inWindow = 1'b1;
    end else begin : g_upper_zero
      assign inWindow = (addr[ADDR_W-1:REGION_AW] == '0);
    end
  endgenerate

  logic hit;
  logic romSel;
  logic ramSel;

  always_comb begin
    hit    = inWindow && !asN;
    romSel = hit && rdWr && strobe.readRom;
    ramSel = hit && (!rdWr || strobe.readRam);
    romCsN = !romSel;
    ramCsN = !ramSel;
  end
endmodule

// File: rtl/boot_shadow_decode.sv
module boot_shadow_decode
  import boot_shadow_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int REGION_BYTES = 1024
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              ramSwN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdWr,
  input  logic              asN,
  output logic              romCsN,
  output logic              ramCsN
);
  ctrlStrobe_t ctrlStrobe;

  boot_shadow_ctrl u_ctrl (
    .clk    (clk),
    .porN   (porN),
    .ramSwN (ramSwN),
    .strobe (ctrlStrobe)
  );

  boot_shadow_dp #(
    .ADDR_W       (ADDR_W),
    .REGION_BYTES (REGION_BYTES)
  ) u_dp (
    .addr   (addr),
    .rdWr   (rdWr),
    .asN    (asN),
    .strobe (ctrlStrobe),
    .romCsN (romCsN),
    .ramCsN (ramCsN)
  );
endmodule

// File: rtl/boot_shadow_sva.sv
module boot_shadow_sva #(
  parameter int ADDR_W       = 24,
  parameter int REGION_BYTES = 1024
) (
  input logic              clk,
  input logic              porN,
  input logic              ramSwN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdWr,
  input logic              asN,
  input logic              romCsN,
  input logic              ramCsN,
  input logic              inRamMode
);
  localparam int REGION_AW = $clog2(REGION_BYTES);

  logic outside;
  assign outside = (REGION_AW < ADDR_W) && ((addr >> REGION_AW) != '0);

  // R1: ROM is only ever selected by a read
  p_rom_read_only_r1: assert property (@(posedge clk) disable iff (!porN)
    !romCsN |-> rdWr);

  // R2: a write in the window always lands in RAM
  p_write_to_ram_r2: assert property (@(posedge clk) disable iff (!porN)
    (!asN && !rdWr && !outside) |-> (!ramCsN && romCsN));

  // R3: a sampled switch request moves the flag
  p_switch_sets_r3: assert property (@(posedge clk) disable iff (!porN)
    !ramSwN |=> inRamMode);

  // R4: the flag never leaves RAM mode without reset
  p_mode_sticky_r4: assert property (@(posedge clk) disable iff (!porN)
    inRamMode |=> inRamMode);

  // R5: no ROM access once shadowed
  p_no_rom_in_ram_r5: assert property (@(posedge clk) disable iff (!porN)
    inRamMode |-> romCsN);

  // R6: idle strobe means no select
  p_idle_r6: assert property (@(posedge clk) disable iff (!porN)
    asN |-> (romCsN && ramCsN));

  // R7: nothing decoded above the window
  p_outside_r7: assert property (@(posedge clk) disable iff (!porN)
    outside |-> (romCsN && ramCsN));

  // never both selects at once
  p_exclusive_r5: assert property (@(posedge clk) disable iff (!porN)
    !(!romCsN && !ramCsN));
endmodule

bind boot_shadow_decode boot_shadow_sva #(
  .ADDR_W       (ADDR_W),
  .REGION_BYTES (REGION_BYTES)
) u_sva (
  .clk       (clk),
  .porN      (porN),
  .ramSwN    (ramSwN),
  .addr      (addr),
  .rdWr      (rdWr),
  .asN       (asN),
  .romCsN    (romCsN),
  .ramCsN    (ramCsN),
  .inRamMode (ctrlStrobe.readRam)
);

// File: tb/boot_shadow_decode_tb.sv
module boot_shadow_decode_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 24;
  localparam int NVEC       = 9;
  localparam int VW         = ADDR_W + 6;

  // {addr, rdWr, asN, bootRomN, bootRamN, ramRomN, ramRamN}
  localparam logic [VW-1:0] VECS [NVEC] = '{
    {24'h000000, 1'b1, 1'b0, 2'b01, 2'b10},  // R1 stack pointer word
    {24'h000004, 1'b1, 1'b0, 2'b01, 2'b10},  // R1 program start word
    {24'h0003FC, 1'b1, 1'b0, 2'b01, 2'b10},  // R1 last longword
    {24'h000100, 1'b0, 1'b0, 2'b10, 2'b10},  // R2 write copy
    {24'h000400, 1'b1, 1'b0, 2'b11, 2'b11},  // R7 first byte above
    {24'h000400, 1'b0, 1'b0, 2'b11, 2'b11},  // R7 write above
    {24'h000000, 1'b1, 1'b1, 2'b11, 2'b11},  // R6 strobe idle
    {24'h800000, 1'b1, 1'b0, 2'b11, 2'b11},  // R7 high address
    {24'h0003FF, 1'b0, 1'b0, 2'b10, 2'b10}   // R2 last byte write
  };

  logic              clk = 1'b0;
  logic              porN = 1'b0;
  logic              ramSwN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              rdWr = 1'b1;
  logic              asN = 1'b1;
  logic              romCsN;
  logic              ramCsN;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_shadow_decode u_dut (
    .clk    (clk),
    .porN   (porN),
    .ramSwN (ramSwN),
    .addr   (addr),
    .rdWr   (rdWr),
    .asN    (asN),
    .romCsN (romCsN),
    .ramCsN (ramCsN)
  );

  task automatic check(input string req, input logic [1:0] exp);
    nChecks++;
    if ({romCsN, ramCsN} !== exp) begin
      nFails++;
      $display("FAIL %s: {romCsN,ramCsN} actual=%b expected=%b addr=%h rdWr=%b asN=%b",
               req, {romCsN, ramCsN}, exp, addr, rdWr, asN);
    end
  endtask

  task automatic drive(input logic [ADDR_W-1:0] a, input logic rw, input logic as);
    @(negedge clk);
    addr = a; rdWr = rw; asN = as;
    #1;
  endtask

  task automatic walk(input bit ramPhase);
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i][VW-1:6], VECS[i][5], VECS[i][4]);
      check(ramPhase ? "R5 table in RAM mode" : "R1/R2 table in boot mode",
            ramPhase ? VECS[i][1:0] : VECS[i][3:2]);
    end
  endtask

  task automatic pulseSwitch();
    @(negedge clk);
    ramSwN = 1'b0;
    @(negedge clk);
    ramSwN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    #1;
    check("R9 idle during reset", 2'b11);
    drive(24'h000000, 1'b1, 1'b0);
    check("R9 boot read during reset", 2'b01);
    drive(24'h000000, 1'b1, 1'b1);
    porN = 1'b1;

    walk(1'b0);

    // R3 switch request
    pulseSwitch();
    drive(24'h000000, 1'b1, 1'b0);
    check("R3 read after switch", 2'b10);
    drive(24'h000004, 1'b1, 1'b0);
    check("R4 held after switch release", 2'b10);
    repeat (5) @(negedge clk);
    #1;
    check("R4 still RAM several cycles later", 2'b10);

    walk(1'b1);

    // R4 only reset returns to boot
    drive(24'h000000, 1'b1, 1'b0);
    porN = 1'b0;
    #1;
    check("R4 reset returns boot", 2'b01);
    @(negedge clk);
    porN = 1'b1;
    #1;
    check("R4 boot after reset release", 2'b01);

    // R8 reset and switch together
    @(negedge clk);
    porN = 1'b0; ramSwN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    porN = 1'b1; ramSwN = 1'b1;
    #1;
    check("R8 reset wins over switch", 2'b01);
    drive(24'h000008, 1'b1, 1'b0);
    check("R8 still boot one cycle on", 2'b01);
    drive(24'h000008, 1'b0, 1'b0);
    check("R2 write after collision", 2'b10);

    // R6 idle strobe in RAM mode
    pulseSwitch();
    drive(24'h000010, 1'b0, 1'b1);
    check("R6 idle strobe in RAM mode", 2'b11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule